// File: doc/BRIEF.md
# Dual-Array Address Translation Lookup

This block converts a 32-bit effective address into a real address. It searches two sets of translation entries at once. The first set holds 256 entries, and each of them maps a 4 KB page. The second set holds 16 entries, and each of them carries its own page-size code. The page size for a code `s` is 1 KB × 4^s. Each entry holds:

- a valid flag;
- an address-space bit;
- an 8-bit translation tag;
- a 20-bit effective page number and a 20-bit real page number, both counted in 4 KB units;
- a size code;
- a 12-bit attribute word.

A lookup is accepted when `lk_req` is high. The address-space bit used for the comparison comes from `msr_is` on instruction fetches and from `msr_ds` on data accesses. Any of three process-ID inputs can satisfy an entry's tag, and a tag of zero matches every process.

The result is registered and appears one cycle after the request. It is either a hit, with the real address and the entry's attributes, or a miss. A miss is the trigger for the surrounding core to raise its translation-miss exception. A single-cycle write port loads every field of one entry in either array.

Top module: `tlb_xlate`

## Requirements
- R1: After reset the only valid entry is variable entry 0. It has address space 0, tag 0 and size code 1, and it maps effective page 0xFFFFF to real page 0xFFFFF. Its attribute word is 0xAA8. The attribute word is laid out as {protect[11], perm[10:5] = {ux,sx,uw,sw,ur,sr}, storage[4:0]}, so 0xAA8 means protected, supervisor read/write/execute only, storage code 0x8.
- R2: An entry whose valid flag is 0 never produces a hit.
- R3: The comparison address-space bit is `msr_is` when `lk_ifetch`=1 and `msr_ds` otherwise. It must equal the entry's address-space bit for a hit.
- R4: An entry with tag 0 matches any process IDs. Any other tag must equal `pid0`, `pid1` or `pid2`.
- R5: A variable entry compares the address bits above bit 10+2·size. A size code of 11 or more compares no bits and so covers the whole space. Fixed entries always compare bits 31:12, whatever their size field holds.
- R6: On a hit, the real address is the real page number shifted left by 12 for the compared bits, and the effective address for the bits below them.
- R7: When several entries match, the lowest-indexed fixed entry wins. A variable entry is used only when no fixed entry matches, and then the lowest-indexed variable entry wins.
- R8: A write with `wr_en`=1 loads the entry chosen by `wr_to_var` (0 = fixed array, 1 = variable array) and `wr_idx`. The new contents apply to lookups presented from the next cycle on. A variable-array write with `wr_idx` ≥ 16 changes nothing.
- R9: The result of a request appears on the cycle after it, with exactly one of `hit_o` or `miss_o` high. Without a request, both stay low. `real_o` and `attr_o` are zero whenever `hit_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| msr_is | input | 1 | Instruction address-space bit |
| msr_ds | input | 1 | Data address-space bit |
| pid0 | input | 8 | Process ID 0 |
| pid1 | input | 8 | Process ID 1 |
| pid2 | input | 8 | Process ID 2 |
| lk_ea | input | 32 | Effective address |
| wr_en | input | 1 | Entry write strobe |
| wr_to_var | input | 1 | Write target: 0 fixed array, 1 variable array |
| wr_idx | input | 8 | Entry index to write |
| wr_valid | input | 1 | Valid flag to write |
| wr_ts | input | 1 | Address-space bit to write |
| wr_tid | input | 8 | Translation tag to write |
| wr_epn | input | 20 | Effective page number (4 KB units) |
| wr_rpn | input | 20 | Real page number (4 KB units) |
| wr_size | input | 4 | Page-size code (variable array only) |
| wr_attr | input | 12 | Attribute word |
| hit_o | output | 1 | Registered hit |
| miss_o | output | 1 | Registered miss |
| real_o | output | 32 | Translated real address |
| attr_o | output | 12 | Attributes of the winning entry |

## Verification
Directed lookups probe each match condition on its own:

- **Address-space select.** The reset entry is looked up with each address-space bit flipped and with fetch and data selects swapped. This shows which bit the comparison uses.
- **Tag match.** Tagged entries are tried with the tag in none of the three ID inputs and then in different ID inputs. This separates the global path from the per-ID match.
- **Page sizes.** Entries of 1 KB, 1 MB and whole-space size are hit at offsets just inside and just outside their pages. This separates the mask width from the offset merge.
- **Priority.** Duplicate pages are placed across indices and across arrays. Invalidating the winner must expose the next candidate.
- **Ignored write.** A variable write at an out-of-range index is checked against an address that would hit if the index had aliased.

Seeded random writes, drawn from a small page pool with mixed tags, spaces and sizes, then produce overlapping matches. Random lookups are compared with a bench reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int EA_W   = 32;
    localparam int PN_W   = 20;
    localparam int PG_SH  = EA_W - PN_W;
    localparam int TID_W  = 8;
    localparam int SZ_W   = 4;
    localparam int ATTR_W = 12;
    localparam int NPID   = 3;

    typedef struct packed {
        logic              valid;
        logic              ts;
        logic [TID_W-1:0]  tid;
        logic [PN_W-1:0]   epn;
        logic [PN_W-1:0]   rpn;
        logic [SZ_W-1:0]   size;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    // Boot mapping: last 4 KB page to itself, protected, supervisor-only, storage code 0x8
    localparam tlb_entry_t BOOT_ENTRY = '{
        valid: 1'b1, ts: 1'b0, tid: '0,
        epn: {PN_W{1'b1}}, rpn: {PN_W{1'b1}},
        size: SZ_W'(1), attr: ATTR_W'(12'hAA8)
    };
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter bit FIXED = 1'b1
) (
    input  tlb_entry_t                  ent,
    input  logic [EA_W-1:0]             ea,
    input  logic                        as_bit,
    input  logic [NPID-1:0][TID_W-1:0]  pids,
    output logic                        hit,
    output logic [EA_W-1:0]             real_addr
);
    localparam int OB_W = 6;

    logic [OB_W-1:0] off_bits;
    logic [EA_W-1:0] mask;
    logic [EA_W-1:0] vpage;
    logic [EA_W-1:0] rpage;
    logic            pid_ok;

    always_comb begin
        if (FIXED) begin
            off_bits = OB_W'(PG_SH);
        end else begin
            off_bits = OB_W'(10) + OB_W'({ent.size, 1'b0});
        end
        if (off_bits >= OB_W'(EA_W)) begin
            mask = '0;
        end else begin
            mask = {EA_W{1'b1}} << off_bits;
        end
        vpage  = {ent.epn, {PG_SH{1'b0}}};
        rpage  = {ent.rpn, {PG_SH{1'b0}}};
        pid_ok = (ent.tid == '0);
        for (int p = 0; p < NPID; p++) begin
            if (pids[p] == ent.tid) pid_ok = 1'b1;
        end
        hit       = ent.valid && (ent.ts == as_bit) && pid_ok
                    && ((ea & mask) == (vpage & mask));
        real_addr = (rpage & mask) | (ea & ~mask);
    end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int N      = 16,
    parameter bit FIXED  = 1'b0,
    parameter int WIDX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WIDX_W-1:0]           wr_idx,
    input  tlb_entry_t                  wr_ent,
    input  logic [EA_W-1:0]             ea,
    input  logic                        as_bit,
    input  logic [NPID-1:0][TID_W-1:0]  pids,
    output logic                        any_hit,
    output logic [EA_W-1:0]             hit_real,
    output logic [ATTR_W-1:0]           hit_attr
);
    localparam int LW = (N > 1) ? $clog2(N) : 1;

    tlb_entry_t      ent_q [N];
    tlb_entry_t      ent_d [N];
    logic [N-1:0]    hit_v;
    logic [EA_W-1:0] real_v [N];

    // next-state of the entry store
    always_comb begin
        for (int i = 0; i < N; i++) ent_d[i] = ent_q[i];
        if (wr_en && (int'(wr_idx) < N)) begin
            ent_d[wr_idx[LW-1:0]] = wr_ent;
            if (FIXED) ent_d[wr_idx[LW-1:0]].size = SZ_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
            if (!FIXED) ent_q[0] <= BOOT_ENTRY;
        end else begin
            for (int i = 0; i < N; i++) ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        tlb_match #(.FIXED(FIXED)) u_match (
            .ent       (ent_q[g]),
            .ea        (ea),
            .as_bit    (as_bit),
            .pids      (pids),
            .hit       (hit_v[g]),
            .real_addr (real_v[g])
        );
    end

    // lowest index wins
    always_comb begin
        any_hit  = |hit_v;
        hit_real = '0;
        hit_attr = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                hit_real = real_v[i];
                hit_attr = ent_q[i].attr;
            end
        end
    end

    // offset bits below 1 KB always pass through (R6)
    assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_real[9:0] == ea[9:0]));

    if (FIXED) begin : g_fixed_chk
        // fixed pages keep a 4 KB offset (R5)
        assert_fixed_4k_R5: assert property (@(posedge clk) disable iff (!rst_n)
            any_hit |-> (hit_real[PG_SH-1:0] == ea[PG_SH-1:0]));
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int FIX_N = 256,
    parameter int VAR_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              lk_ifetch,
    input  logic              msr_is,
    input  logic              msr_ds,
    input  logic [7:0]        pid0,
    input  logic [7:0]        pid1,
    input  logic [7:0]        pid2,
    input  logic [31:0]       lk_ea,
    input  logic              wr_en,
    input  logic              wr_to_var,
    input  logic [7:0]        wr_idx,
    input  logic              wr_valid,
    input  logic              wr_ts,
    input  logic [7:0]        wr_tid,
    input  logic [19:0]       wr_epn,
    input  logic [19:0]       wr_rpn,
    input  logic [3:0]        wr_size,
    input  logic [11:0]       wr_attr,
    output logic              hit_o,
    output logic              miss_o,
    output logic [31:0]       real_o,
    output logic [11:0]       attr_o
);
    localparam int MAX_N  = (FIX_N > VAR_N) ? FIX_N : VAR_N;
    localparam int WIDX_W = $clog2(MAX_N);

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [EA_W-1:0]   real_a;
        logic [ATTR_W-1:0] attr;
    } out_t;

    out_t out_d, out_q;

    logic                       as_bit;
    logic [NPID-1:0][TID_W-1:0] pids;
    tlb_entry_t                 wr_ent;
    logic                       fix_hit, var_hit;
    logic [EA_W-1:0]            fix_real, var_real;
    logic [ATTR_W-1:0]          fix_attr, var_attr;

    assign as_bit = lk_ifetch ? msr_is : msr_ds;
    assign pids   = {pid2, pid1, pid0};
    assign wr_ent = '{valid: wr_valid, ts: wr_ts, tid: wr_tid, epn: wr_epn,
                      rpn: wr_rpn, size: wr_size, attr: wr_attr};

    tlb_bank #(.N(FIX_N), .FIXED(1'b1), .WIDX_W(WIDX_W)) u_fix (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && !wr_to_var),
        .wr_idx   (wr_idx[WIDX_W-1:0]),
        .wr_ent   (wr_ent),
        .ea       (lk_ea),
        .as_bit   (as_bit),
        .pids     (pids),
        .any_hit  (fix_hit),
        .hit_real (fix_real),
        .hit_attr (fix_attr)
    );

    tlb_bank #(.N(VAR_N), .FIXED(1'b0), .WIDX_W(WIDX_W)) u_var (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en && wr_to_var),
        .wr_idx   (wr_idx[WIDX_W-1:0]),
        .wr_ent   (wr_ent),
        .ea       (lk_ea),
        .as_bit   (as_bit),
        .pids     (pids),
        .any_hit  (var_hit),
        .hit_real (var_real),
        .hit_attr (var_attr)
    );

    always_comb begin
        out_d = '0;
        if (lk_req) begin
            if (fix_hit) begin
                out_d.hit    = 1'b1;
                out_d.real_a = fix_real;
                out_d.attr   = fix_attr;
            end else if (var_hit) begin
                out_d.hit    = 1'b1;
                out_d.real_a = var_real;
                out_d.attr   = var_attr;
            end else begin
                out_d.miss   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hit_o  = out_q.hit;
    assign miss_o = out_q.miss;
    assign real_o = out_q.real_a;
    assign attr_o = out_q.attr;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!hit_o && !miss_o));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (hit_o != miss_o));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (real_o == '0 && attr_o == '0));
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
    typedef struct {
        bit        valid;
        bit        ts;
        bit [7:0]  tid;
        bit [19:0] epn;
        bit [19:0] rpn;
        bit [3:0]  size;
        bit [11:0] attr;
    } ment_t;

    typedef struct {
        bit        hit;
        bit [31:0] real_a;
        bit [11:0] attr;
    } mres_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 1'b0, lk_ifetch = 1'b0, msr_is = 1'b0, msr_ds = 1'b0;
    logic [7:0] pid0 = '0, pid1 = '0, pid2 = '0;
    logic [31:0] lk_ea = '0;
    logic wr_en = 1'b0, wr_to_var = 1'b0, wr_valid = 1'b0, wr_ts = 1'b0;
    logic [7:0] wr_idx = '0, wr_tid = '0;
    logic [19:0] wr_epn = '0, wr_rpn = '0;
    logic [3:0] wr_size = '0;
    logic [11:0] wr_attr = '0;
    logic hit_o, miss_o;
    logic [31:0] real_o;
    logic [11:0] attr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ment_t mfix [256];
    ment_t mvar [16];

    always #2 clk = ~clk;

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ifetch(lk_ifetch),
        .msr_is(msr_is), .msr_ds(msr_ds), .pid0(pid0), .pid1(pid1), .pid2(pid2),
        .lk_ea(lk_ea), .wr_en(wr_en), .wr_to_var(wr_to_var), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_ts(wr_ts), .wr_tid(wr_tid), .wr_epn(wr_epn),
        .wr_rpn(wr_rpn), .wr_size(wr_size), .wr_attr(wr_attr),
        .hit_o(hit_o), .miss_o(miss_o), .real_o(real_o), .attr_o(attr_o)
    );

    function automatic bit [31:0] size_mask(input bit fixed, input bit [3:0] sz);
        int ob;
        ob = fixed ? 12 : 10 + 2 * int'(sz);
        if (ob >= 32) return 32'h0;
        return 32'hFFFF_FFFF << ob;
    endfunction

    function automatic bit ent_match(input ment_t e, input bit fixed, input bit [31:0] ea,
                                     input bit asb, input bit [7:0] p0, p1, p2);
        bit [31:0] m;
        if (!e.valid || e.ts != asb) return 0;
        if (e.tid != 0 && e.tid != p0 && e.tid != p1 && e.tid != p2) return 0;
        m = size_mask(fixed, e.size);
        return (ea & m) == ({e.epn, 12'h0} & m);
    endfunction

    function automatic mres_t model(input bit [31:0] ea, input bit asb,
                                    input bit [7:0] p0, p1, p2);
        mres_t r;
        bit [31:0] m;
        r = '{hit: 0, real_a: 0, attr: 0};
        for (int i = 0; i < 256; i++) begin
            if (ent_match(mfix[i], 1, ea, asb, p0, p1, p2)) begin
                m = size_mask(1, 0);
                r = '{hit: 1, real_a: ({mfix[i].rpn, 12'h0} & m) | (ea & ~m), attr: mfix[i].attr};
                return r;
            end
        end
        for (int i = 0; i < 16; i++) begin
            if (ent_match(mvar[i], 0, ea, asb, p0, p1, p2)) begin
                m = size_mask(0, mvar[i].size);
                r = '{hit: 1, real_a: ({mvar[i].rpn, 12'h0} & m) | (ea & ~m), attr: mvar[i].attr};
                return r;
            end
        end
        return r;
    endfunction

    task automatic write_ent(input bit tv, input bit [7:0] idx, input bit v, input bit ts,
                             input bit [7:0] tid, input bit [19:0] epn, input bit [19:0] rpn,
                             input bit [3:0] sz, input bit [11:0] at);
        @(negedge clk);
        wr_en = 1; wr_to_var = tv; wr_idx = idx; wr_valid = v; wr_ts = ts;
        wr_tid = tid; wr_epn = epn; wr_rpn = rpn; wr_size = sz; wr_attr = at;
        @(negedge clk);
        wr_en = 0;
        if (!tv) mfix[idx] = '{v, ts, tid, epn, rpn, sz, at};
        else if (idx < 16) mvar[idx[3:0]] = '{v, ts, tid, epn, rpn, sz, at};
    endtask

    task automatic look(input bit [31:0] ea, input bit ifetch, input bit is_b, input bit ds_b,
                        input bit [7:0] p0, p1, p2, input string tag);
        mres_t e;
        @(negedge clk);
        lk_req = 1; lk_ea = ea; lk_ifetch = ifetch; msr_is = is_b; msr_ds = ds_b;
        pid0 = p0; pid1 = p1; pid2 = p2;
        e = model(ea, ifetch ? is_b : ds_b, p0, p1, p2);
        @(negedge clk);
        lk_req = 0;
        checks++;
        if (hit_o !== e.hit || miss_o !== !e.hit || real_o !== e.real_a || attr_o !== e.attr) begin
            errors++;
            $display("FAIL %s ea=%h: hit/miss/real/attr got %b/%b/%h/%h expected %b/%b/%h/%h",
                     tag, ea, hit_o, miss_o, real_o, attr_o, e.hit, !e.hit, e.real_a, e.attr);
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        lk_req = 0;
        @(negedge clk);
        checks++;
        if (hit_o !== 0 || miss_o !== 0 || real_o !== 0 || attr_o !== 0) begin
            errors++;
            $display("FAIL %s idle: hit/miss/real/attr got %b/%b/%h/%h expected 0/0/0/0",
                     tag, hit_o, miss_o, real_o, attr_o);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mres_t e;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 256; i++) mfix[i] = '{0, 0, 0, 0, 0, 0, 0};
        for (int i = 0; i < 16; i++) mvar[i] = '{0, 0, 0, 0, 0, 0, 0};
        mvar[0] = '{1, 0, 8'h00, 20'hFFFFF, 20'hFFFFF, 4'd1, 12'hAA8};
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9 and R1: idle outputs after reset
        expect_idle("R9 reset");
        // R1: boot mapping, checked against literal values too
        e = model(32'hFFFF_F123, 0, 0, 0, 0);
        checks++;
        if (!(e.hit && e.real_a == 32'hFFFF_F123 && e.attr == 12'hAA8)) begin
            errors++;
            $display("FAIL R1 model: got %b/%h/%h expected 1/fffff123/aa8", e.hit, e.real_a, e.attr);
        end
        look(32'hFFFF_F123, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R1 boot page");
        look(32'h0000_1000, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R1 other page misses");
        // R3: address-space selection
        look(32'hFFFF_F004, 0, 0, 1, 8'h00, 8'h00, 8'h00, "R3 data ds=1 misses");
        look(32'hFFFF_F004, 1, 0, 1, 8'h00, 8'h00, 8'h00, "R3 fetch uses is");
        look(32'hFFFF_F004, 1, 1, 0, 8'h00, 8'h00, 8'h00, "R3 fetch is=1 misses");

        // R6 composition, R7 priority, R2 invalid, R8 writes
        write_ent(0, 8'd3, 1, 0, 8'h00, 20'h12345, 20'hABCDE, 4'd9, 12'h123);
        look(32'h1234_5678, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R6 fixed real address");
        write_ent(0, 8'd10, 1, 0, 8'h00, 20'h12345, 20'h11111, 4'd0, 12'h456);
        write_ent(1, 8'd2, 1, 0, 8'h00, 20'h12345, 20'h22222, 4'd1, 12'h789);
        look(32'h1234_5FFF, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 lowest fixed wins");
        write_ent(0, 8'd3, 0, 0, 8'h00, 20'h12345, 20'hABCDE, 4'd1, 12'h123);
        look(32'h1234_5001, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R2 invalid skipped R8 rewrite");
        write_ent(0, 8'd10, 0, 0, 8'h00, 20'h12345, 20'h11111, 4'd1, 12'h456);
        look(32'h1234_5002, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R7 variable used when no fixed");

        // R4 tag matching
        write_ent(0, 8'd20, 1, 0, 8'h07, 20'h40000, 20'h50000, 4'd1, 12'h0F0);
        look(32'h4000_0ABC, 0, 0, 0, 8'h01, 8'h02, 8'h03, "R4 tag absent misses");
        look(32'h4000_0ABC, 0, 0, 0, 8'h01, 8'h02, 8'h07, "R4 tag in pid2");
        look(32'h4000_0ABC, 0, 0, 0, 8'h07, 8'h00, 8'h09, "R4 tag in pid0");

        // R5 page sizes
        write_ent(1, 8'd6, 1, 0, 8'h00, 20'h20000, 20'h30000, 4'd0, 12'h011);
        look(32'h2000_03FF, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R5 1KB inside");
        look(32'h2000_0400, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R5 1KB outside misses");
        write_ent(1, 8'd7, 1, 0, 8'h00, 20'h60000, 20'h70000, 4'd5, 12'h022);
        look(32'h600A_BCDE, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R5 1MB page");
        look(32'h6010_0000, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R5 1MB outside misses");
        write_ent(1, 8'd5, 1, 1, 8'h00, 20'h00000, 20'h00000, 4'd11, 12'h033);
        look(32'h9876_5432, 0, 0, 1, 8'h00, 8'h00, 8'h00, "R5 whole-space page");
        look(32'h0000_0000, 1, 1, 0, 8'h00, 8'h00, 8'h00, "R5 whole-space fetch");

        // R8: variable index beyond 16 is ignored (would alias to index 4)
        write_ent(1, 8'd20, 1, 0, 8'h00, 20'h80000, 20'h81000, 4'd1, 12'h044);
        look(32'h8000_0010, 0, 0, 0, 8'h00, 8'h00, 8'h00, "R8 out-of-range var write ignored");
        expect_idle("R9 no request");

        // random mix: R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 400; n++) begin
            bit [19:0] pool [8];
            bit [31:0] ea;
            pool = '{20'h12345, 20'h40000, 20'h20000, 20'h60000, 20'h80000, 20'h00010, 20'hFFFFF, 20'h60010};
            if ($urandom_range(0, 2) == 0) begin
                write_ent($urandom_range(0, 1) == 1, 8'($urandom_range(0, 40)),
                          $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0,
                          8'($urandom_range(0, 4)), pool[$urandom_range(0, 7)],
                          20'($urandom), 4'($urandom_range(0, 12)), 12'($urandom));
            end
            ea = {pool[$urandom_range(0, 7)], 12'($urandom)};
            if ($urandom_range(0, 4) == 0) ea = $urandom;
            look(ea, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                 8'($urandom_range(0, 4)), 8'($urandom_range(0, 4)), 8'($urandom_range(0, 4)),
                 "R7 random lookup");
            if ($urandom_range(0, 15) == 0) expect_idle("R9 random idle");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule